// File: doc/BRIEF.md
# Partitioned 8x16 Rounding Multiplier

This block multiplies unsigned 8-bit pixel components by signed 16-bit coefficients in several parallel lanes in one pass. Each lane takes the signed product, drops its low eight bits and rounds half up, giving a 16-bit result. A 3-bit opcode picks where each lane's 8-bit factor and 16-bit coefficient come from. The factor can be a packed byte, or the high or low byte of a 16-bit lane. The coefficient can be a per-lane value or one shared alpha value. One two-lane form spreads its results into 32-bit fields.

A caller presents both 64-bit operands and an opcode with `inValid` high for one cycle. On the next clock edge the result is registered and `resValid` pulses. An opcode the block does not define gives a zero result and raises `opErr` in the same cycle as `resValid`.

Top module: `pmulTop`

## Requirements
- R1: Each lane computes p = f * c, where f is an unsigned 8-bit factor and c is a signed 16-bit coefficient, and p is a two's-complement product. The lane result is p[23:8] plus p[7].
- R2: The lane result is kept to 16 bits, so the round-up increment wraps within 16 bits. For example, f=1 and c=0xFF80 give 0x0000.
- R3: Opcode 0 (per-lane): lane i (0..3) uses f = opA[8i+7:8i] and c = opB[16i+15:16i], and its result sits at result[16i+15:16i].
- R4: Opcode 1 (shared alpha, high) uses c = opB[31:16] for all four lanes. Opcode 2 (shared alpha, low) uses c = opB[15:0]. In both, f = opA[8i+7:8i] and the result sits at result[16i+15:16i].
- R5: Opcode 3 uses f = opA[16i+15:16i+8] and opcode 4 uses f = opA[16i+7:16i]. Both use c = opB[16i+15:16i], with four lanes placed as in R3.
- R6: Opcodes 5 (high byte) and 6 (low byte) run two lanes, with f taken as in R5 and c = opB[16i+15:16i] for i = 0..1. Lane i's result sits at result[32i+22:32i+7], and every other result bit is zero.
- R7: `resValid` is high exactly one cycle after a cycle with `inValid` high. `result` and `opErr` change only on those cycles and otherwise hold their values.
- R8: Opcode 7 is undefined. It gives `result` = 0 and `opErr` = 1 alongside `resValid`. Defined opcodes give `opErr` = 0.
- R9: While `rstN` is low, `resValid`, `opErr` and `result` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Operands and opcode are valid this cycle |
| op | input | 3 | Variant select (0..6 defined, 7 undefined) |
| opA | input | 64 | Factor operand |
| opB | input | 64 | Coefficient operand |
| resValid | output | 1 | Result registered from the previous cycle's request |
| result | output | 64 | Packed lane results |
| opErr | output | 1 | Previous request used an undefined opcode |

## Verification
On every cycle, the assertions check the one-cycle request-to-result timing and that the result holds between requests. They also check that an undefined opcode gives a zero result with the error flag set, and that the two-lane forms leave every bit outside their two fields at zero. Only the bench's sweeps can show the lane arithmetic itself. Those sweeps cover the rounding, the 16-bit wrap of the increment, and the correct choice of factor byte and coefficient for each variant. They run every factor value against a set of extreme and mid-range coefficients, and compare each result with an arithmetic model.

// File: rtl/pmulPkg.sv
package pmulPkg;
  typedef enum logic [2:0] {
    OP_LANE     = 3'd0,
    OP_ALPHA_HI = 3'd1,
    OP_ALPHA_LO = 3'd2,
    OP_WHI      = 3'd3,
    OP_WLO      = 3'd4,
    OP_DBL_HI   = 3'd5,
    OP_DBL_LO   = 3'd6,
    OP_BAD      = 3'd7
  } pmulOpE;

  typedef struct packed {
    logic load;      // capture a new result
    logic bad;       // undefined opcode, force zero
    logic useAlpha;  // one shared coefficient
    logic alphaHi;   // shared coefficient from upper half
    logic wordByte;  // factor is a byte of a 16-bit lane
    logic byteHi;    // high byte of that lane
    logic dbl;       // two lanes in 32-bit fields
  } pmulCtrlS;
endpackage

// File: rtl/pmulLane.sv
module pmulLane #(
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16
) (
  input  logic [BYTE_W-1:0] factor,
  input  logic [COEF_W-1:0] coef,
  output logic [COEF_W-1:0] laneOut
);
  localparam int PW = BYTE_W + COEF_W;
  logic signed [PW:0] prod;
  logic [PW:0] prodBits;

  always_comb begin
    prod     = $signed({1'b0, factor}) * $signed(coef);
    prodBits = prod;
    laneOut  = prodBits[PW-1:BYTE_W] + {{(COEF_W-1){1'b0}}, prodBits[BYTE_W-1]};
  end
endmodule

// File: rtl/pmulCtrl.sv
module pmulCtrl
  import pmulPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     inValid,
  input  logic [2:0] op,
  output pmulCtrlS ctrl,
  output logic     resValid,
  output logic     opErr
);
  always_comb begin
    ctrl          = '0;
    ctrl.load     = inValid;
    case (pmulOpE'(op))
      OP_LANE:     ;
      OP_ALPHA_HI: begin ctrl.useAlpha = 1'b1; ctrl.alphaHi = 1'b1; end
      OP_ALPHA_LO: ctrl.useAlpha = 1'b1;
      OP_WHI:      begin ctrl.wordByte = 1'b1; ctrl.byteHi = 1'b1; end
      OP_WLO:      ctrl.wordByte = 1'b1;
      OP_DBL_HI:   begin ctrl.wordByte = 1'b1; ctrl.byteHi = 1'b1; ctrl.dbl = 1'b1; end
      OP_DBL_LO:   begin ctrl.wordByte = 1'b1; ctrl.dbl = 1'b1; end
      default:     ctrl.bad = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resValid <= 1'b0;
      opErr    <= 1'b0;
    end else begin
      resValid <= inValid;
      if (inValid) opErr <= ctrl.bad;
    end
  end
endmodule

// File: rtl/pmulData.sv
module pmulData
  import pmulPkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16,
  parameter int DBL_OFS = 7
) (
  input  logic     clk,
  input  logic     rstN,
  input  pmulCtrlS ctrl,
  input  logic [LANES*COEF_W-1:0] opA,
  input  logic [LANES*COEF_W-1:0] opB,
  output logic [LANES*COEF_W-1:0] result
);
  localparam int DW      = LANES * COEF_W;
  localparam int DLANES  = LANES / 2;
  localparam int FIELD_W = 2 * COEF_W;

  logic [COEF_W-1:0] laneRes [LANES];
  logic [COEF_W-1:0] alphaCoef;
  logic [DW-1:0]     packed4;
  logic [DW-1:0]     packed2;

  assign alphaCoef = ctrl.alphaHi ? opB[2*COEF_W-1:COEF_W] : opB[COEF_W-1:0];

  for (genvar i = 0; i < LANES; i++) begin : gLane
    logic [BYTE_W-1:0] factor;
    logic [COEF_W-1:0] coef;
    always_comb begin
      if (ctrl.wordByte)
        factor = ctrl.byteHi ? opA[COEF_W*i+BYTE_W +: BYTE_W] : opA[COEF_W*i +: BYTE_W];
      else
        factor = opA[BYTE_W*i +: BYTE_W];
      coef = ctrl.useAlpha ? alphaCoef : opB[COEF_W*i +: COEF_W];
    end
    pmulLane #(.BYTE_W(BYTE_W), .COEF_W(COEF_W)) uLane (
      .factor(factor), .coef(coef), .laneOut(laneRes[i])
    );
  end

  always_comb begin
    packed4 = '0;
    packed2 = '0;
    for (int i = 0; i < LANES; i++) packed4[COEF_W*i +: COEF_W] = laneRes[i];
    for (int i = 0; i < DLANES; i++) packed2[FIELD_W*i+DBL_OFS +: COEF_W] = laneRes[i];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          result <= '0;
    else if (ctrl.load) result <= ctrl.bad ? '0 : (ctrl.dbl ? packed2 : packed4);
  end
endmodule

// File: rtl/pmulTop.sv
module pmulTop
  import pmulPkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  parameter int COEF_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    inValid,
  input  logic [2:0]              op,
  input  logic [LANES*COEF_W-1:0] opA,
  input  logic [LANES*COEF_W-1:0] opB,
  output logic                    resValid,
  output logic [LANES*COEF_W-1:0] result,
  output logic                    opErr
);
  pmulCtrlS ctrl;

  pmulCtrl uCtrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op),
    .ctrl(ctrl), .resValid(resValid), .opErr(opErr)
  );

  pmulData #(.LANES(LANES), .BYTE_W(BYTE_W), .COEF_W(COEF_W)) uData (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .opA(opA), .opB(opB), .result(result)
  );
endmodule

// File: rtl/pmulChecker.sv
module pmulChecker (
  input logic        clk,
  input logic        rstN,
  input logic        inValid,
  input logic [2:0]  op,
  input logic        resValid,
  input logic [63:0] result,
  input logic        opErr
);
  assert_valid_follows_R7: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> resValid);
  assert_valid_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !resValid);
  assert_result_holds_R7: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(result) && $stable(opErr)));
  assert_bad_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op == 3'd7) |=> (opErr && result == 64'd0));
  assert_good_noerr_R8: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && op != 3'd7) |=> !opErr);
  assert_dbl_gaps_R6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (op == 3'd5 || op == 3'd6)) |=>
      (result[6:0] == 7'd0 && result[38:23] == 16'd0 && result[63:55] == 9'd0));
endmodule

bind pmulTop pmulChecker uChk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .op(op),
  .resValid(resValid), .result(result), .opErr(opErr)
);

// File: tb/pmulTop_test.sv
module pmulTop_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  op = 3'd0;
  logic [63:0] opA = '0;
  logic [63:0] opB = '0;
  logic        resValid;
  logic [63:0] result;
  logic        opErr;
  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pmulTop uut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op), .opA(opA), .opB(opB),
    .resValid(resValid), .result(result), .opErr(opErr)
  );

  logic [15:0] coefs [16] = '{16'h0000, 16'h0001, 16'h7fff, 16'h8000, 16'hffff,
    16'hff80, 16'h0080, 16'h0100, 16'h00ff, 16'h1234, 16'hedcb, 16'h4000,
    16'hc000, 16'h0081, 16'hff7f, 16'h5a5a};

  function automatic logic [15:0] laneModel(input logic [7:0] f, input logic [15:0] c);
    int p;
    logic signed [15:0] cs;
    cs = c;
    p = int'(f) * int'(cs);
    return 16'((p >>> 8) + ((p >>> 7) & 1));
  endfunction

  function automatic logic [63:0] model(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] r = '0;
    for (int i = 0; i < 4; i++) begin
      case (o)
        3'd0: r[16*i +: 16] = laneModel(a[8*i +: 8], b[16*i +: 16]);
        3'd1: r[16*i +: 16] = laneModel(a[8*i +: 8], b[31:16]);
        3'd2: r[16*i +: 16] = laneModel(a[8*i +: 8], b[15:0]);
        3'd3: r[16*i +: 16] = laneModel(a[16*i+8 +: 8], b[16*i +: 16]);
        3'd4: r[16*i +: 16] = laneModel(a[16*i +: 8], b[16*i +: 16]);
        3'd5: if (i < 2) r[32*i+7 +: 16] = laneModel(a[16*i+8 +: 8], b[16*i +: 16]);
        3'd6: if (i < 2) r[32*i+7 +: 16] = laneModel(a[16*i +: 8], b[16*i +: 16]);
        default: ;
      endcase
    end
    return r;
  endfunction

  function automatic string reqOf(input logic [2:0] o);
    case (o)
      3'd0: return "R3";
      3'd1, 3'd2: return "R4";
      3'd3, 3'd4: return "R5";
      3'd5, 3'd6: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input logic [2:0] o, input logic [63:0] a, input logic [63:0] b, input string req);
    @(negedge clk);
    inValid = 1'b1; op = o; opA = a; opB = b;
    @(negedge clk);
    inValid = 1'b0;
    check(req, {result, 3'd0, resValid, 3'd0, opErr}, {model(o, a, b), 3'd0, 1'b1, 3'd0, (o == 3'd7)});
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [63:0] held;
    #1;
    check("R9", {result, 3'd0, resValid, 3'd0, opErr}, 72'd0);
    repeat (3) @(negedge clk);
    check("R9", {result, 3'd0, resValid, 3'd0, opErr}, 72'd0);
    rstN = 1'b1;
    // R1/R2 directed corners
    run(3'd0, 64'h0000_0000_ff01_01ff, 64'h7fff_8000_ff80_0080, "R1");
    check("R2", result[31:16], 16'h0000);
    run(3'd0, 64'h0000_0000_0101_0101, 64'hff80_ff80_ff80_ff80, "R2");
    // sweep every factor against the coefficient set for all opcodes
    for (int o = 0; o < 8; o++) begin
      for (int v = 0; v < 256; v++) begin
        for (int k = 0; k < 16; k++) begin
          logic [63:0] a, b;
          for (int j = 0; j < 8; j++) a[8*j +: 8] = 8'(v + 53*j);
          for (int j = 0; j < 4; j++) b[16*j +: 16] = coefs[(k + 5*j) & 15];
          run(3'(o), a, b, reqOf(3'(o)));
        end
      end
    end
    // R7: idle cycles hold the result and keep resValid low
    run(3'd0, 64'h0000_0000_80c0_e0f0, 64'h1234_4000_c000_7fff, "R7");
    held = result;
    @(negedge clk);
    check("R7", {result, 7'd0, resValid}, {held, 8'd0});
    opA = '1; opB = '1; op = 3'd7;
    @(negedge clk);
    check("R7", {result, 3'd0, resValid, 3'd0, opErr}, {held, 8'd0});
    // R8 then a good opcode clears the error
    run(3'd7, '1, '1, "R8");
    run(3'd1, 64'h0000_0000_0102_0304, 64'h0000_0000_0200_ff00, "R8");
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule